// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block drives a group of external memory-control pins from a small on-chip store of 32-bit control words. Each word presents one clock cycle of pin levels and carries three flags: one that ends the pattern, one that makes the word eligible for wait stalling, and one that marks the cycle as a data transfer. A requester names a start index, and the sequencer then walks through consecutive words until it reaches a word whose end flag is set.

After a pattern ends, the pins return to logic 1 unless another request is already queued. A queued request is chained directly, with no idle cycle between the two patterns. An external wait input passes through one register. When the wait input is high and the previous word had wait-enable set, the sequencer freezes in place and holds all pins. The pattern store is loaded through a plain address/data/write-enable host port, and that port only takes effect while no pattern is running.

Requests use a valid/ready handshake that holds one request. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the queued request is launched. A requester that sees `req_ready` low keeps `req_valid` and `req_start` steady until it is accepted.

Top module: `pattern_sequencer`

## Requirements
- R1: During and after reset, `pins` is all ones, `dval` is 0, `req_ready` is 1, and no pattern runs.
- R2: A host write made while idle stores `host_wdata` at `host_addr`. Bits [7:0] of a word give the pin levels. A request accepted on edge E puts the start word on `pins` after edge E+1, and each following cycle presents the word at the next index.
- R3: When the presented word has bit 31 (end flag) set, is not frozen, and no request is queued, `pins` becomes all ones in the next cycle and stays there while idle.
- R4: When a request is queued as the end word is presented, the next cycle presents the queued pattern's start word with no cycle of ones between the patterns. `req_ready` is low from acceptance until that launch.
- R5: The sequencer freezes when the registered wait input is high and the previous word had bit 30 (wait-enable) set. While frozen, `pins` holds the presented word and the index does not advance.
- R6: Once the registered wait input is seen low, the frozen word is presented for one unfrozen cycle, and the next cycle presents the following word.
- R7: If the frozen word itself has bit 30 clear, the freeze lasts at most one cycle, even when the wait input stays high.
- R8: `dval` is 1 exactly in cycles where the presented word has bit 29 (transfer flag) set and the sequencer is not frozen.
- R9: A host write made while a pattern is being presented is dropped. The stored word stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for the pattern store |
| host_addr | input | 6 | Host write index |
| host_wdata | input | 32 | Host write word |
| req_valid | input | 1 | Pattern request valid |
| req_start | input | 6 | Start index of the requested pattern |
| req_ready | output | 1 | Request slot free |
| mem_wait | input | 1 | External wait input, active high |
| pins | output | 8 | Memory-control pin levels |
| dval | output | 1 | Data-valid strobe |

## Verification
The embedded properties check the following on every cycle:
- the pins park high after an unchained end word;
- a chained launch takes place;
- the pins and the index hold while frozen;
- the index steps by one when a non-end word advances;
- a freeze ends within one cycle when the frozen word lacks wait-enable;
- the request slot fills after acceptance.

Only the directed scenarios can show the following:
- the exact cycle at which the first word appears;
- how a release of the wait input lines up with the resumed sequence;
- that `dval` is suppressed during a freeze and returns afterwards;
- that a host write during a run leaves the stored word unchanged, which the bench sees by re-running that pattern.

// File: rtl/mps_pkg.sv
package mps_pkg;
  localparam int WORD_W   = 32;
  localparam int END_BIT  = 31;
  localparam int WEN_BIT  = 30;
  localparam int XFER_BIT = 29;

  typedef struct packed {
    logic is_end;
    logic wait_en;
    logic xfer;
  } word_flags_t;

  function automatic word_flags_t decode_flags(input logic [WORD_W-1:0] w);
    word_flags_t f;
    f.is_end  = w[END_BIT];
    f.wait_en = w[WEN_BIT];
    f.xfer    = w[XFER_BIT];
    return f;
  endfunction
endpackage

// File: rtl/mps_store.sv
module mps_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mps_wait_sync.sv
module mps_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_in,
  output logic wait_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_in;
  end
endmodule

// File: rtl/mps_core.sv
module mps_core
  import mps_pkg::*;
#(
  parameter int AW    = 6,
  parameter int PIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_start,
  output logic              req_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              wait_q,
  output logic [PIN_W-1:0]  pins_o,
  output logic              dval_o,
  output logic              busy_o
);
  logic              active_q;
  logic [WORD_W-1:0] word_q;
  logic [AW-1:0]     idx_q;
  logic [PIN_W-1:0]  pins_q;
  logic              pend_q;
  logic [AW-1:0]     pend_idx_q;
  logic              wen_prev_q;

  word_flags_t       flg;
  logic              frozen, step, finish, launch;
  logic [AW-1:0]     nxt_idx;

  always_comb begin
    flg     = decode_flags(word_q);
    frozen  = active_q && wen_prev_q && wait_q;
    step    = active_q && !frozen;
    finish  = step && flg.is_end;
    launch  = pend_q && (!active_q || finish);
    nxt_idx = launch ? pend_idx_q : idx_q + AW'(1);
  end

  assign rd_addr   = nxt_idx;
  assign req_ready = !pend_q;
  assign pins_o    = pins_q;
  assign dval_o    = active_q && flg.xfer && !frozen;
  assign busy_o    = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      word_q     <= '0;
      idx_q      <= '0;
      pins_q     <= '1;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      wen_prev_q <= 1'b0;
    end else begin
      if (req_valid && !pend_q) begin
        pend_q     <= 1'b1;
        pend_idx_q <= req_start;
      end else if (launch) begin
        pend_q <= 1'b0;
      end
      wen_prev_q <= active_q && flg.wait_en;
      if (launch || (step && !flg.is_end)) begin
        active_q <= 1'b1;
        word_q   <= rd_data;
        idx_q    <= nxt_idx;
        pins_q   <= rd_data[PIN_W-1:0];
      end else if (finish) begin
        active_q <= 1'b0;
        word_q   <= '0;
        pins_q   <= '1;
      end
    end
  end

  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !pend_q) |=> (pins_o == {PIN_W{1'b1}} && !busy_o)); // R3

  AST_CHAIN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && pend_q) |=> (busy_o && req_ready)); // R4

  AST_SLOT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R4

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(pins_o) && $stable(idx_q))); // R5

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flg.is_end) |=> (idx_q == $past(idx_q) + AW'(1))); // R6

  AST_SHORT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !flg.wait_en) |=> !frozen); // R7
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int DEPTH = 64,
  parameter int PIN_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = mps_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [W-1:0]     host_wdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_start,
  output logic             req_ready,
  input  logic             mem_wait,
  output logic [PIN_W-1:0] pins,
  output logic             dval
);
  logic          busy;
  logic          wait_q;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data;
  logic          store_we;

  assign store_we = host_we && !busy;

  mps_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .wr_en(store_we), .wr_addr(host_addr), .wr_data(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mps_wait_sync u_wait (
    .clk(clk), .rst_n(rst_n), .wait_in(mem_wait), .wait_q(wait_q)
  );

  mps_core #(.AW(AW), .PIN_W(PIN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
    .req_ready(req_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wait_q(wait_q), .pins_o(pins), .dval_o(dval), .busy_o(busy)
  );
endmodule

// File: tb/pattern_sequencer_test.sv
module pattern_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_start = '0;
  logic        req_ready;
  logic        mem_wait = 1'b0;
  logic [7:0]  pins;
  logic        dval;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_sequencer uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .req_valid(req_valid), .req_start(req_start),
    .req_ready(req_ready), .mem_wait(mem_wait), .pins(pins), .dval(dval)
  );

  function automatic logic [31:0] mkw(bit e, bit w, bit x, logic [7:0] p);
    return {e, w, x, 21'd0, p};
  endfunction

  task automatic expect_out(string req, logic [7:0] ep, logic ed);
    n_tests++;
    if (pins !== ep || dval !== ed) begin
      n_fail++;
      $display("FAIL %s: pins=%h dval=%b expected pins=%h dval=%b", req, pins, dval, ep, ed);
    end
  endtask

  task automatic expect_ready(string req, logic er);
    n_tests++;
    if (req_ready !== er) begin
      n_fail++;
      $display("FAIL %s: req_ready=%b expected %b", req, req_ready, er);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic host_write(logic [5:0] a, logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send_req(logic [5:0] s);
    req_valid = 1'b1; req_start = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R1 reset pins", 8'hFF, 1'b0);
    expect_ready("R1 reset ready", 1'b1);
  endtask

  task automatic t_basic;
    send_req(6'd0);
    @(negedge clk); expect_out("R2 first word", 8'hA1, 1'b0);
    @(negedge clk); expect_out("R8 xfer word", 8'hB2, 1'b1);
    @(negedge clk); expect_out("R2 third word", 8'hC3, 1'b0);
    @(negedge clk); expect_out("R3 park high", 8'hFF, 1'b0);
    @(negedge clk); expect_out("R3 stays high", 8'hFF, 1'b0);
  endtask

  task automatic t_chain;
    send_req(6'd4);
    @(negedge clk); expect_out("R2 chain A first", 8'h41, 1'b0);
    send_req(6'd8);
    expect_out("R4 A end word", 8'h42, 1'b0);
    expect_ready("R4 ready low while queued", 1'b0);
    @(negedge clk); expect_out("R4 B start no gap", 8'h81, 1'b0);
    expect_ready("R4 ready back", 1'b1);
    @(negedge clk); expect_out("R4 B end word", 8'h82, 1'b0);
    @(negedge clk); expect_out("R3 park after B", 8'hFF, 1'b0);
  endtask

  task automatic t_wait_pair;
    mem_wait = 1'b1;
    send_req(6'd16);
    @(negedge clk); expect_out("R5 pre word", 8'h11, 1'b0);
    @(negedge clk); expect_out("R5 first wen word", 8'h22, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); expect_out("R5 R8 frozen", 8'h33, 1'b0);
    end
    mem_wait = 1'b0;
    @(negedge clk); expect_out("R6 R8 unfrozen same word", 8'h33, 1'b1);
    @(negedge clk); expect_out("R6 resume next", 8'h44, 1'b0);
    @(negedge clk); expect_out("R6 end word", 8'h55, 1'b0);
    @(negedge clk); expect_out("R3 park after wait", 8'hFF, 1'b0);
  endtask

  task automatic t_wait_single;
    mem_wait = 1'b1;
    send_req(6'd21);
    @(negedge clk); expect_out("R7 wen word", 8'h61, 1'b0);
    @(negedge clk); expect_out("R7 one freeze cycle", 8'h62, 1'b0);
    @(negedge clk); expect_out("R7 freeze released", 8'h62, 1'b1);
    @(negedge clk); expect_out("R7 advance with wait high", 8'h63, 1'b0);
    @(negedge clk); expect_out("R3 park", 8'hFF, 1'b0);
    mem_wait = 1'b0;
  endtask

  task automatic t_write_guard;
    send_req(6'd24);
    @(negedge clk); expect_out("R9 run start", 8'h71, 1'b0);
    host_write(6'd24, mkw(0, 0, 0, 8'h0F));
    expect_out("R9 run second", 8'h72, 1'b0);
    @(negedge clk); expect_out("R9 park", 8'hFF, 1'b0);
    send_req(6'd24);
    @(negedge clk); expect_out("R9 busy write dropped", 8'h71, 1'b0);
    @(negedge clk); @(negedge clk);
    host_write(6'd24, mkw(0, 0, 0, 8'h0F));
    send_req(6'd24);
    @(negedge clk); expect_out("R2 idle write stored", 8'h0F, 1'b0);
    @(negedge clk); expect_out("R2 next after rewrite", 8'h72, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    host_write(6'd0,  mkw(0, 0, 0, 8'hA1));
    host_write(6'd1,  mkw(0, 0, 1, 8'hB2));
    host_write(6'd2,  mkw(1, 0, 0, 8'hC3));
    host_write(6'd4,  mkw(0, 0, 0, 8'h41));
    host_write(6'd5,  mkw(1, 0, 0, 8'h42));
    host_write(6'd8,  mkw(0, 0, 0, 8'h81));
    host_write(6'd9,  mkw(1, 0, 0, 8'h82));
    host_write(6'd16, mkw(0, 0, 0, 8'h11));
    host_write(6'd17, mkw(0, 1, 0, 8'h22));
    host_write(6'd18, mkw(0, 1, 1, 8'h33));
    host_write(6'd19, mkw(0, 0, 0, 8'h44));
    host_write(6'd20, mkw(1, 0, 0, 8'h55));
    host_write(6'd21, mkw(0, 1, 0, 8'h61));
    host_write(6'd22, mkw(0, 0, 1, 8'h62));
    host_write(6'd23, mkw(1, 0, 0, 8'h63));
    host_write(6'd24, mkw(0, 0, 0, 8'h71));
    host_write(6'd25, mkw(1, 0, 0, 8'h72));
    t_basic();
    t_chain();
    t_wait_pair();
    t_wait_single();
    t_write_guard();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule